// File: doc/BRIEF.md
# Infrared Pulse-Distance Frame Transmitter

This block turns an 8-bit address and an 8-bit command into a baseband infrared frame on one active-low output line. The line idles high and every burst pulls it low. A data frame opens with a long low leader and a high pause. Thirty-two bit cells follow, and each cell is a fixed low burst and then a high gap whose length gives the bit value. A closing low burst ends the frame. The payload carries the address and the command, and each byte is followed by its bitwise complement so that a receiver can reject a corrupted frame.

A second strobe sends the short repeat frame, which a receiver takes to mean "the last key is still held". That frame is the leader low, a shorter high pause and the closing burst, with no payload. All durations are parameters given in clock cycles. The defaults assume a 50 MHz clock: 9 ms leader, 4.5 ms pause, 2.25 ms repeat pause, 560 us burst, 560 us zero gap and 1.69 ms one gap. A bench can scale them down. Carrier modulation is left to logic further along the path.

Top module: `ir_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `ir_o` is high and `busy_o` is low.
- R2: A data frame begins with `ir_o` low for exactly T_LEAD_LO cycles, followed by `ir_o` high for exactly T_LEAD_HI cycles.
- R3: Every bit cell is `ir_o` low for T_BURST cycles, then high for T_GAP0 cycles for a 0 or T_GAP1 cycles for a 1.
- R4: The 32 payload bits are, in time order, the address, the complemented address, the command and the complemented command.
- R5: Within each byte the least significant bit goes first. Address 0x57 therefore appears as 1,1,1,0,1,0,1,0.
- R6: After the 32nd gap, `ir_o` is low for T_BURST cycles. In the cycle the line returns high, `busy_o` drops.
- R7: A repeat strobe sends `ir_o` low for T_LEAD_LO cycles, then high for T_REP_HI cycles, then low for T_BURST cycles, then back to idle.
- R8: A strobe sampled high at a rising edge while idle makes `busy_o` high and `ir_o` low from that edge.
- R9: Strobes that arrive while `busy_o` is high have no effect. The frame in progress is unchanged and no further frame follows it.
- R10: The address and command are captured at the accepting edge. Later changes on `addr_i` and `cmd_i` do not change the frame.
- R11: When `send_i` and `repeat_i` are both high in the accepting cycle, a full data frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | BYTE_W | Address byte to send |
| cmd_i | input | BYTE_W | Command byte to send |
| send_i | input | 1 | Request a full data frame |
| repeat_i | input | 1 | Request a repeat frame |
| ir_o | output | 1 | Line level, low during bursts |
| busy_o | output | 1 | High while a frame is on the line |

## Verification
Data frames are sent with the 0x57/0x22 pair, with all-zero and all-ones bytes, and with alternating patterns. Between them these show byte order, bit order and complement placement, and let a swapped or uninverted byte be told apart from a correct one. The all-zero and all-ones bytes also separate the two gap lengths. A repeat frame checks that its shorter pause and the missing payload differ from a data frame. Strobes and input changes injected mid-frame, together with a strobe that carries both requests at once, exercise the capture, ignore and priority rules. Each frame is checked as a list of low and high intervals, and the 32 gaps are decoded back into a word.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEAD_LO,
      PH_LEAD_HI,
      PH_BIT_LO,
      PH_BIT_HI,
      PH_STOP_LO
   } phase_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ir_seg_timer.sv
module ir_seg_timer #(
   parameter int CNT_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // a running segment counts down by one every cycle (segment lengths, R2 R3)
   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ir_payload_shift.sv
module ir_payload_shift #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] addr_i,
   input  logic [BYTE_W-1:0] cmd_i,
   input  logic              load,
   input  logic              shift,
   output logic              cur_bit,
   output logic              last_bit
);

   localparam int NUM_FIELDS = 2;
   localparam int FRAME_BITS = 2 * NUM_FIELDS * BYTE_W;
   localparam int IDX_W      = $clog2(FRAME_BITS);

   logic [BYTE_W-1:0]     fields [NUM_FIELDS];
   logic [FRAME_BITS-1:0] frame_w;
   logic [FRAME_BITS-1:0] sr_q;
   logic [IDX_W-1:0]      idx_q;

   assign fields[0] = addr_i;
   assign fields[1] = cmd_i;

   // each field is followed by its complement; bit 0 leaves first
   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      assign frame_w[2*g*BYTE_W +: BYTE_W]          = fields[g];
      assign frame_w[(2*g+1)*BYTE_W +: BYTE_W]      = ~fields[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         idx_q <= '0;
      end else if (load) begin
         sr_q  <= frame_w;
         idx_q <= '0;
      end else if (shift) begin
         sr_q  <= sr_q >> 1;
         idx_q <= idx_q + 1'b1;
      end
   end

   assign cur_bit  = sr_q[0];
   assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));

   // captured payload is frozen between capture and shift steps
   assert_payload_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !shift) |=> $stable(sr_q));

endmodule

// File: rtl/ir_frame_tx.sv
module ir_frame_tx
   import ir_tx_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int T_LEAD_LO = 450000,
   parameter int T_LEAD_HI = 225000,
   parameter int T_REP_HI  = 112500,
   parameter int T_BURST   = 28000,
   parameter int T_GAP0    = 28000,
   parameter int T_GAP1    = 84500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] addr_i,
   input  logic [BYTE_W-1:0] cmd_i,
   input  logic              send_i,
   input  logic              repeat_i,
   output logic              ir_o,
   output logic              busy_o
);

   localparam int unsigned T_MAX =
      max2(max2(T_LEAD_LO, T_LEAD_HI), max2(max2(T_REP_HI, T_BURST), max2(T_GAP0, T_GAP1)));
   localparam int CNT_W = $clog2(T_MAX + 1);

   localparam logic [CNT_W-1:0] LV_LEAD_LO = CNT_W'(T_LEAD_LO - 1);
   localparam logic [CNT_W-1:0] LV_LEAD_HI = CNT_W'(T_LEAD_HI - 1);
   localparam logic [CNT_W-1:0] LV_REP_HI  = CNT_W'(T_REP_HI - 1);
   localparam logic [CNT_W-1:0] LV_BURST   = CNT_W'(T_BURST - 1);
   localparam logic [CNT_W-1:0] LV_GAP0    = CNT_W'(T_GAP0 - 1);
   localparam logic [CNT_W-1:0] LV_GAP1    = CNT_W'(T_GAP1 - 1);

   if (BYTE_W < 1)
      $error("BYTE_W must be at least 1");
   if (T_LEAD_LO < 1 || T_LEAD_HI < 1 || T_REP_HI < 1 || T_BURST < 1 || T_GAP0 < 1)
      $error("every segment needs at least one cycle");
   if (T_GAP1 <= T_GAP0)
      $error("the one gap must be longer than the zero gap");
   if (T_LEAD_HI <= T_REP_HI)
      $error("the repeat pause must be shorter than the leader pause");

   phase_e           ph_q, ph_nxt;
   logic             rep_q, rep_nxt;
   logic             t_load, t_expired;
   logic [CNT_W-1:0] t_val;
   logic             pl_load, pl_shift, pl_bit, pl_last;

   ir_seg_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_expired)
   );

   ir_payload_shift #(.BYTE_W(BYTE_W)) i_payload (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (addr_i),
      .cmd_i    (cmd_i),
      .load     (pl_load),
      .shift    (pl_shift),
      .cur_bit  (pl_bit),
      .last_bit (pl_last)
   );

   always_comb begin
      ph_nxt   = ph_q;
      rep_nxt  = rep_q;
      t_load   = 1'b0;
      t_val    = '0;
      pl_load  = 1'b0;
      pl_shift = 1'b0;
      unique case (ph_q)
         PH_IDLE: begin
            if (send_i || repeat_i) begin
               ph_nxt  = PH_LEAD_LO;
               t_load  = 1'b1;
               t_val   = LV_LEAD_LO;
               rep_nxt = !send_i;
               pl_load = send_i;
            end
         end
         PH_LEAD_LO: begin
            if (t_expired) begin
               ph_nxt = PH_LEAD_HI;
               t_load = 1'b1;
               t_val  = rep_q ? LV_REP_HI : LV_LEAD_HI;
            end
         end
         PH_LEAD_HI: begin
            if (t_expired) begin
               ph_nxt = rep_q ? PH_STOP_LO : PH_BIT_LO;
               t_load = 1'b1;
               t_val  = LV_BURST;
            end
         end
         PH_BIT_LO: begin
            if (t_expired) begin
               ph_nxt = PH_BIT_HI;
               t_load = 1'b1;
               t_val  = pl_bit ? LV_GAP1 : LV_GAP0;
            end
         end
         PH_BIT_HI: begin
            if (t_expired) begin
               ph_nxt   = pl_last ? PH_STOP_LO : PH_BIT_LO;
               t_load   = 1'b1;
               t_val    = LV_BURST;
               pl_shift = 1'b1;
            end
         end
         PH_STOP_LO: begin
            if (t_expired)
               ph_nxt = PH_IDLE;
         end
         default: ph_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         rep_q <= 1'b0;
      end else begin
         ph_q  <= ph_nxt;
         rep_q <= rep_nxt;
      end
   end

   assign busy_o = (ph_q != PH_IDLE);
   assign ir_o   = !(ph_q == PH_LEAD_LO || ph_q == PH_BIT_LO || ph_q == PH_STOP_LO);

   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> ir_o);

   assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && (send_i || repeat_i)) |=> (busy_o && !ir_o));

   assert_stop_before_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> ($past(ph_q) == PH_STOP_LO));

   assert_last_cell_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_BIT_HI && t_expired && pl_last) |=> (ph_q == PH_STOP_LO));

   assert_repeat_no_payload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_LEAD_HI && rep_q && t_expired) |=> (ph_q == PH_STOP_LO));

   assert_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && ph_q != PH_STOP_LO) |=> busy_o);

endmodule

// File: tb/test_ir_frame_tx.sv
module test_ir_frame_tx;

   localparam int CLK_PERIOD = 20;
   localparam int LL = 36;
   localparam int LH = 18;
   localparam int RH = 9;
   localparam int B  = 4;
   localparam int G0 = 4;
   localparam int G1 = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = 8'h00;
   logic [7:0] cmd = 8'h00;
   logic       send = 1'b0;
   logic       rep = 1'b0;
   logic       ir;
   logic       busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic        exp_lvl [$];
   int          exp_len [$];
   string       exp_req [$];
   logic [31:0] exp_word [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ir_frame_tx #(
      .BYTE_W(8), .T_LEAD_LO(LL), .T_LEAD_HI(LH), .T_REP_HI(RH),
      .T_BURST(B), .T_GAP0(G0), .T_GAP1(G1)
   ) i_ir_frame_tx (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .cmd_i(cmd),
      .send_i(send), .repeat_i(rep), .ir_o(ir), .busy_o(busy)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic push_seg(input logic l, input int n, input string r);
      exp_lvl.push_back(l);
      exp_len.push_back(n);
      exp_req.push_back(r);
   endtask

   task automatic push_data(input logic [7:0] a, input logic [7:0] c);
      logic [31:0] w;
      w = {~c, c, ~a, a};
      push_seg(1'b0, LL, "R2");
      push_seg(1'b1, LH, "R2");
      for (int i = 0; i < 32; i++) begin
         push_seg(1'b0, B, "R3");
         push_seg(1'b1, w[i] ? G1 : G0, "R3");
      end
      push_seg(1'b0, B, "R6");
      exp_word.push_back(w);
   endtask

   task automatic push_repeat();
      push_seg(1'b0, LL, "R7");
      push_seg(1'b1, RH, "R7");
      push_seg(1'b0, B, "R7");
   endtask

   // monitor: measures each interval while busy and compares it with the queue
   int          run_len = 0;
   logic        run_lvl = 1'b1;
   int          run_idx = 0;
   logic [31:0] dec = '0;

   task automatic close_run();
      if (exp_len.size() == 0) begin
         check(1'b0, "R9", "unexpected interval length", run_len, 0);
      end else begin
         logic  el;
         int    en;
         string er;
         el = exp_lvl.pop_front();
         en = exp_len.pop_front();
         er = exp_req.pop_front();
         check(el == run_lvl, er, "interval level", run_lvl, el);
         check(en == run_len, er, "interval length", run_len, en);
      end
      if (run_lvl && run_idx >= 3 && run_idx <= 65 && (run_idx % 2) == 1)
         dec[(run_idx - 3) / 2] = (run_len == G1);
      run_idx++;
      run_len = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) begin
            if (run_len > 0 && ir != run_lvl)
               close_run();
            run_lvl = ir;
            run_len++;
         end else if (run_len > 0) begin
            close_run();
            if (run_idx == 67) begin
               if (exp_word.size() == 0)
                  check(1'b0, "R4", "decoded word without expectation", dec, 0);
               else begin
                  logic [31:0] ew;
                  ew = exp_word.pop_front();
                  check(dec == ew, "R4 R5", "decoded payload", dec, ew);
               end
            end
            run_idx = 0;
         end
      end
   end

   task automatic strobe(input logic s, input logic r);
      @(negedge clk);
      send = s;
      rep  = r;
      @(negedge clk);
      send = 1'b0;
      rep  = 1'b0;
      check(busy && !ir, "R8", "busy and low after strobe", {busy, ir}, 2'b10);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      check(ir == 1'b1, "R6", "line high when busy drops", ir, 1);
      repeat (3) @(negedge clk);
      check(exp_len.size() == 0, "R6", "intervals left in queue", exp_len.size(), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check(ir == 1'b1 && busy == 1'b0, "R1", "reset state", {ir, busy}, 2'b10);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(ir == 1'b1 && busy == 1'b0, "R1", "idle after reset", {ir, busy}, 2'b10);

      // R2 R3 R4 R5: address 0x57, command 0x22
      addr = 8'h57; cmd = 8'h22;
      push_data(8'h57, 8'h22);
      strobe(1'b1, 1'b0);
      wait_idle();

      // R3: all-zero and all-ones bytes
      addr = 8'h00; cmd = 8'hFF;
      push_data(8'h00, 8'hFF);
      strobe(1'b1, 1'b0);
      wait_idle();

      // R9 R10: strobes and input changes during a frame
      addr = 8'hA5; cmd = 8'h3C;
      push_data(8'hA5, 8'h3C);
      strobe(1'b1, 1'b0);
      repeat (100) @(negedge clk);
      addr = 8'h12; cmd = 8'h34;
      send = 1'b1; rep = 1'b1;
      @(negedge clk);
      send = 1'b0; rep = 1'b0;
      repeat (200) @(negedge clk);
      addr = 8'hFF; cmd = 8'h00;
      send = 1'b1;
      @(negedge clk);
      send = 1'b0;
      wait_idle();

      // R7: repeat frame, with a send strobe ignored during it (R9)
      push_repeat();
      strobe(1'b0, 1'b1);
      repeat (10) @(negedge clk);
      send = 1'b1;
      @(negedge clk);
      send = 1'b0;
      wait_idle();

      // R11: both requests at once give a data frame
      addr = 8'h81; cmd = 8'h7E;
      push_data(8'h81, 8'h7E);
      strobe(1'b1, 1'b1);
      wait_idle();

      // R1: line stays idle with no request
      repeat (20) @(negedge clk);
      check(ir == 1'b1 && busy == 1'b0, "R1", "idle with no request", {ir, busy}, 2'b10);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R6 watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule